// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a bus peripheral that multiplies two operands placed in its registers and leaves the product, or the running sum of products, in a pair of result registers. Software chooses the operation with the address it uses to write the first operand. There are four first-operand addresses: unsigned multiply, signed multiply, unsigned accumulate and signed accumulate. The write to the second-operand register starts the operation. The new result is registered on that same clock edge, so a read in the very next cycle already returns it and no wait states are needed.

Each operand write may be a full word or a narrow write that supplies only the low half-word. A narrow value is widened with its sign bit in the signed modes and with zeros in the unsigned modes, which covers the full-by-full, full-by-half, half-by-full and half-by-half size combinations. A third result word, the extension word, holds either the carry out of an accumulation or the sign of the result. Both result words can be written directly, so software can preload a starting accumulator value.

Top module: `mac_unit`

## Requirements
- R1: After reset, every address reads back zero.
- R2: Writing a first operand at address 0, 1, 2 or 3 selects unsigned multiply, signed multiply, unsigned accumulate or signed accumulate. The selected mode is the value of address bits [1:0]. A read of any of these four addresses returns the stored first operand.
- R3: When `bus_byte` is high, an operand write takes only bits [7:0] of the data. The stored value is sign-extended in a signed mode and zero-extended in an unsigned mode. The first operand follows the mode of the address it is written to, and the second operand (address 4) follows the mode currently selected. A read of address 4 returns the widened second operand.
- R4: A write to address 4 starts the operation. The low result (address 5), the high result (address 6) and the extension word (address 7) show the outcome to a read in the cycle right after that write.
- R5: In unsigned multiply mode, the high and low result form the 32-bit unsigned product, and the extension word is 0x0000.
- R6: In signed multiply mode, the high and low result form the two's-complement product. The extension word is 0xFFFF when the product is negative and 0x0000 otherwise.
- R7: In unsigned accumulate mode, the unsigned product is added to the 32-bit result already held. The low 32 bits of the sum are stored, and the extension word becomes the carry out (0x0001 or 0x0000).
- R8: In signed accumulate mode, the signed product is added to the held result, read as a signed 32-bit value. The low 32 bits of the sum are stored. The extension word is 0xFFFF when the exact sum is negative and 0x0000 otherwise.
- R9: Writes to addresses 5 and 6 load the full data word into the low and high result, whatever `bus_byte` is. They leave the extension word unchanged, and a following accumulate adds onto the loaded value.
- R10: Writes to address 7 have no effect.
- R11: A first-operand write leaves the result registers unchanged. The first operand stays valid for any number of later second-operand writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_byte | input | 1 | Narrow operand write: only the low half-word is used |
| bus_addr | input | 3 | Register address for both reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at `bus_addr`, combinational |

## Verification
Two functions can fall in the same cycle. The first is a result preload through addresses 5 and 6. The second is an accumulate that reads that result on the very next edge. The bench drives a preload and then a second-operand write in back-to-back cycles, and checks that the sum is built on the preloaded value rather than on the older one. A further case reads the result in the cycle straight after the second-operand write, checking that the new product is visible with no extra cycles. A sweep then runs each mode over narrow and full operands at sign and carry boundaries, letting accumulations chain so that carries and sign changes happen. Every result is compared with integer arithmetic worked out in the bench.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int unsigned REG_ADDR_W = 3;

    // mode number equals bits [1:0] of the first-operand address
    typedef enum logic [1:0] {
        MD_UMUL = 2'd0,
        MD_SMUL = 2'd1,
        MD_UMAC = 2'd2,
        MD_SMAC = 2'd3
    } mac_mode_e;

    localparam logic [REG_ADDR_W-1:0] A_OP2  = 3'd4;
    localparam logic [REG_ADDR_W-1:0] A_RLO  = 3'd5;
    localparam logic [REG_ADDR_W-1:0] A_RHI  = 3'd6;
    localparam logic [REG_ADDR_W-1:0] A_SEXT = 3'd7;

    function automatic logic mode_signed(mac_mode_e m);
        return m[0];
    endfunction

    function automatic logic mode_accum(mac_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/mac_opnd_ext.sv
module mac_opnd_ext #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              narrow,
    input  logic              sgn,
    output logic [DATA_W-1:0] ext
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned FILL_W = DATA_W - HALF_W;

    logic fill_bit;

    always_comb begin
        fill_bit = sgn & raw[HALF_W-1];
        if (narrow) begin
            ext = {{FILL_W{fill_bit}}, raw[HALF_W-1:0]};
        end else begin
            ext = raw;
        end
    end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic [2*DATA_W-1:0] acc,
    input  mac_mode_e           mode,
    output logic [2*DATA_W-1:0] res,
    output logic [DATA_W-1:0]   sext
);
    localparam int unsigned PROD_W = 2 * DATA_W;
    localparam int unsigned WIDE_W = 2 * DATA_W + 2;
    localparam int unsigned PAD_W  = DATA_W + 1;

    logic                     sgn;
    logic                     accum;
    logic signed [WIDE_W-1:0] a_w;
    logic signed [WIDE_W-1:0] b_w;
    logic signed [WIDE_W-1:0] prod_full;
    logic [PROD_W-1:0]        prod;
    logic [PROD_W:0]          sum;

    assign sgn   = mode_signed(mode);
    assign accum = mode_accum(mode);

    // operands widened so one signed multiplier serves both signednesses
    assign a_w = $signed({{PAD_W{sgn & opa[DATA_W-1]}}, opa, 1'b0}) >>> 1;
    assign b_w = $signed({{PAD_W{sgn & opb[DATA_W-1]}}, opb, 1'b0}) >>> 1;
    assign prod_full = a_w * b_w;
    assign prod      = prod_full[PROD_W-1:0];

    // one extra bit holds carry (unsigned) or true sign (signed)
    assign sum = {sgn & acc[PROD_W-1], acc} + {sgn & prod[PROD_W-1], prod};

    always_comb begin
        if (accum) begin
            res = sum[PROD_W-1:0];
            if (sgn) begin
                sext = {DATA_W{sum[PROD_W]}};
            end else begin
                sext = {{(DATA_W-1){1'b0}}, sum[PROD_W]};
            end
        end else begin
            res = prod;
            if (sgn) begin
                sext = {DATA_W{prod[PROD_W-1]}};
            end else begin
                sext = '0;
            end
        end
    end
endmodule

// File: rtl/mac_rd_mux.sv
module mac_rd_mux
    import mac_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     op1,
    input  logic [DATA_W-1:0]     op2,
    input  logic [DATA_W-1:0]     rlo,
    input  logic [DATA_W-1:0]     rhi,
    input  logic [DATA_W-1:0]     sext,
    output logic [DATA_W-1:0]     rdata
);
    always_comb begin
        if (!addr[REG_ADDR_W-1]) begin
            rdata = op1;
        end else begin
            case (addr)
                A_OP2:   rdata = op2;
                A_RLO:   rdata = rlo;
                A_RHI:   rdata = rhi;
                default: rdata = sext;
            endcase
        end
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_byte,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam int unsigned PROD_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] op1;
        logic [DATA_W-1:0] op2;
        mac_mode_e         mode;
        logic [DATA_W-1:0] rlo;
        logic [DATA_W-1:0] rhi;
        logic [DATA_W-1:0] sext;
    } mac_state_t;

    mac_state_t        st_d;
    mac_state_t        st_q;
    logic [DATA_W-1:0] op1_ext;
    logic [DATA_W-1:0] op2_ext;
    logic [PROD_W-1:0] dp_res;
    logic [DATA_W-1:0] dp_sext;
    logic              op1_wr;

    assign op1_wr = bus_wr & ~bus_addr[REG_ADDR_W-1];

    mac_opnd_ext #(.DATA_W(DATA_W)) u_ext_a (
        .raw    (bus_wdata),
        .narrow (bus_byte),
        .sgn    (bus_addr[0]),
        .ext    (op1_ext)
    );

    mac_opnd_ext #(.DATA_W(DATA_W)) u_ext_b (
        .raw    (bus_wdata),
        .narrow (bus_byte),
        .sgn    (mode_signed(st_q.mode)),
        .ext    (op2_ext)
    );

    mac_datapath #(.DATA_W(DATA_W)) u_dp (
        .opa  (st_q.op1),
        .opb  (op2_ext),
        .acc  ({st_q.rhi, st_q.rlo}),
        .mode (st_q.mode),
        .res  (dp_res),
        .sext (dp_sext)
    );

    mac_rd_mux #(.DATA_W(DATA_W)) u_rd (
        .addr  (bus_addr),
        .op1   (st_q.op1),
        .op2   (st_q.op2),
        .rlo   (st_q.rlo),
        .rhi   (st_q.rhi),
        .sext  (st_q.sext),
        .rdata (bus_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (op1_wr) begin
            st_d.op1  = op1_ext;
            st_d.mode = mac_mode_e'(bus_addr[1:0]);
        end else if (bus_wr) begin
            case (bus_addr)
                A_OP2: begin
                    st_d.op2  = op2_ext;
                    st_d.rlo  = dp_res[DATA_W-1:0];
                    st_d.rhi  = dp_res[PROD_W-1:DATA_W];
                    st_d.sext = dp_sext;
                end
                A_RLO:   st_d.rlo = bus_wdata;
                A_RHI:   st_d.rhi = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    mode_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op1_wr |=> (st_q.mode == mac_mode_e'($past(bus_addr[1:0]))));

    // R5
    umul_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OP2 && st_q.mode == MD_UMUL) |=> (st_q.sext == '0));

    // R6
    smul_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OP2 && st_q.mode == MD_SMUL)
        |=> (st_q.sext == {DATA_W{st_q.rhi[DATA_W-1]}}));

    // R7
    umac_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OP2 && st_q.mode == MD_UMAC)
        |=> (st_q.sext[DATA_W-1:1] == '0));

    // R8
    smac_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OP2 && st_q.mode == MD_SMAC)
        |=> ($countones(st_q.sext) == 0 || $countones(st_q.sext) == DATA_W));

    // R9
    preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_RLO) |=> (st_q.rlo == $past(bus_wdata) && $stable(st_q.sext)));

    // R10
    sext_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SEXT) |=> ($stable(st_q.sext) && $stable(st_q.rlo) && $stable(st_q.rhi)));

    // R11
    op1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op1_wr |=> ($stable(st_q.rlo) && $stable(st_q.rhi) && $stable(st_q.sext)));
endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_byte = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    longint m_acc = 0;
    longint m_ext = 0;

    always #4 clk = ~clk;

    mac_unit u_mac_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_byte  (bus_byte),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic nb);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_byte = nb;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic longint widen(input logic [15:0] v, input bit nb, input bit sg);
        longint x;
        if (nb) begin
            x = longint'(v[7:0]);
            if (sg && v[7]) x = x - 256;
        end else begin
            x = longint'(v);
            if (sg && v[15]) x = x - 65536;
        end
        return x;
    endfunction

    // compute expected result of an operation and update the model
    task automatic model_op(input int md, input longint a, input longint b);
        longint p;
        longint s;
        longint accs;
        p = a * b;
        if (md == 0 || md == 1) begin
            m_acc = p & 64'hFFFF_FFFF;
            m_ext = (md == 1 && p < 0) ? 64'hFFFF : 0;
        end else if (md == 2) begin
            s = m_acc + p;
            m_acc = s & 64'hFFFF_FFFF;
            m_ext = (s >>> 32) & 1;
        end else begin
            accs = (m_acc >= 64'h8000_0000) ? m_acc - 64'h1_0000_0000 : m_acc;
            s = accs + p;
            m_acc = s & 64'hFFFF_FFFF;
            m_ext = (s < 0) ? 64'hFFFF : 0;
        end
    endtask

    task automatic check_result(input string req);
        logic [15:0] v;
        rd(3'd5, v); check(req, v, 16'(m_acc));
        rd(3'd6, v); check(req, v, 16'(m_acc >> 16));
        rd(3'd7, v); check(req, v, 16'(m_ext));
    endtask

    logic [15:0] pat [11] = '{16'h0000, 16'h0001, 16'h0002, 16'h007F, 16'h0080, 16'h00FF,
                              16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hFEDC};

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        string tag;
        longint a;
        longint b;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < 8; k++) begin
            rd(3'(k), v);
            check("R1", v, 16'h0000);
        end

        // R2 op1 visible at all four op1 addresses
        wr(3'd2, 16'h00AB, 1'b0);
        rd(3'd0, v); check("R2", v, 16'h00AB);
        rd(3'd1, v); check("R2", v, 16'h00AB);
        rd(3'd3, v); check("R2", v, 16'h00AB);

        // R3 narrow op1 writes: signed address sign-extends, unsigned zero-extends
        wr(3'd1, 16'h5A80, 1'b1);
        rd(3'd1, v); check("R3", v, 16'hFF80);
        wr(3'd0, 16'h5A80, 1'b1);
        rd(3'd0, v); check("R3", v, 16'h0080);

        // R4 / R5 result readable in the cycle right after the op2 write
        wr(3'd0, 16'h0003, 1'b0);
        wr(3'd4, 16'h0007, 1'b0);
        rd(3'd5, v); check("R4", v, 16'h0015);
        rd(3'd6, v); check("R5", v, 16'h0000);

        // R9 preload and accumulate on the very next edge (back-to-back)
        m_ext = 0;
        wr(3'd2, 16'h0003, 1'b0);
        wr(3'd5, 16'h0001, 1'b0);
        wr(3'd6, 16'h0000, 1'b0);
        wr(3'd4, 16'h0005, 1'b0);
        rd(3'd5, v); check("R9", v, 16'h0010);
        rd(3'd6, v); check("R9", v, 16'h0000);

        // R9 preload leaves the extension word alone
        wr(3'd1, 16'hFFFF, 1'b0);
        wr(3'd4, 16'h0001, 1'b0);
        wr(3'd5, 16'h1111, 1'b1);
        wr(3'd6, 16'h2222, 1'b0);
        rd(3'd7, v); check("R9", v, 16'hFFFF);
        rd(3'd5, v); check("R9", v, 16'h1111);

        // R10 extension word ignores writes
        wr(3'd7, 16'h1234, 1'b0);
        rd(3'd7, v); check("R10", v, 16'hFFFF);
        rd(3'd6, v); check("R10", v, 16'h2222);

        // R11 op1 write leaves results; op1 reused by two op2 writes
        wr(3'd0, 16'h0100, 1'b0);
        rd(3'd5, v); check("R11", v, 16'h1111);
        rd(3'd7, v); check("R11", v, 16'hFFFF);
        wr(3'd4, 16'h0002, 1'b0);
        wr(3'd4, 16'h0003, 1'b0);
        rd(3'd5, v); check("R11", v, 16'h0300);

        // sweep: every mode, operand size mix and boundary pattern
        for (int md = 0; md < 4; md++) begin
            case (md)
                0: tag = "R5";
                1: tag = "R6";
                2: tag = "R7";
                default: tag = "R8";
            endcase
            wr(3'd5, 16'hFFF0, 1'b0);
            wr(3'd6, 16'hFFFF, 1'b0);
            m_acc = 64'hFFFF_FFF0;
            for (int n1 = 0; n1 < 2; n1++) begin
                for (int n2 = 0; n2 < 2; n2++) begin
                    for (int i = 0; i < 11; i++) begin
                        for (int j = 0; j < 11; j++) begin
                            a = widen(pat[i], n1[0], md[0]);
                            b = widen(pat[j], n2[0], md[0]);
                            wr(3'(md), pat[i], n1[0]);
                            wr(3'd4, pat[j], n2[0]);
                            model_op(md, a, b);
                            check_result(tag);
                            rd(3'd4, v);
                            check("R3", v, 16'(b));
                        end
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule